// File: doc/BRIEF.md
# Interruptible Keyed Block XOR Mover

This block moves a run of words from one region of a word-addressed memory to another and XORs every word with a key on the way. Software loads the source base, the destination base, the number of words and two keys, then pulses `start`. The engine works from the top of the block down to the bottom. The word at the highest index takes the first key, and the two keys then alternate word by word. It drives a single synchronous memory port and keeps one access outstanding at a time: a read of the source word, then a write of the result.

Between pairs of words the engine looks at an external interrupt-pending flag. It yields only when the wakeup-disable count is zero. A yield leaves the remaining count, the bases and the keys in place and sets a one-entry restart indication on `stackDepth`. Pulsing `resume` later finishes the words that are left, and the key order stays unbroken. A normal finish clears `stackDepth` to zero.

Top module: `xor_mover`

## Requirements
- R1: A job started with a word count of zero raises `done` without issuing any memory write.
- R2: For a count of N, the k-th write (k = 0 first) goes to dstAddr+N-1-k, and the read just before it comes from srcAddr+N-1-k.
- R3: The word at index j is written as source word j XOR keyA when (N-1-j) is even, and XOR keyB when it is odd.
- R4: With an odd remaining count, the engine completes right after the single last word and does not sample the interrupt flag for it.
- R5: After every second word, and only then, a pending interrupt with wakeDisable equal to zero makes the engine stop and pulse `yielded` instead of `done`.
- R6: A pending interrupt is ignored while wakeDisable is nonzero, and the job runs to completion.
- R7: After a yield, `remCount` holds the number of unprocessed words and `stackDepth` reads 1. A `resume` pulse then processes exactly those words with the same alternation and ends with `done`.
- R8: `done` is accompanied by `stackDepth` equal to zero.
- R9: `busy` is high from the cycle after a start or resume until the cycle in which `done` or `yielded` pulses. A `start` while busy changes nothing.
- R10: Only one memory access is active per cycle, and every write is directly preceded by the read of the same word. Equal source and destination bases therefore give a correct in-place result.
- R11: A job of N words with no yield keeps `busy` high for exactly 3N + floor(N/2) + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load operands and begin a job (ignored while busy) |
| resume | input | 1 | Continue a yielded job from retained state |
| srcAddr | input | AW | Source block base address |
| dstAddr | input | AW | Destination block base address |
| wordCount | input | CW | Number of words to move |
| keyA | input | DW | Key for the first word and every second one after it |
| keyB | input | DW | Key for the remaining words |
| irqPending | input | 1 | Interrupt-pending flag |
| wakeDisable | input | WDW | Wakeup-disable counter; interrupts are taken only at zero |
| memRdata | input | DW | Read data, valid the cycle after a read request |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the current access |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| yielded | output | 1 | One-cycle pulse when the engine stops for an interrupt |
| remCount | output | CW | Retained count of unprocessed words |
| stackDepth | output | SDW | Restart indication: 0 after completion, 1 after a yield |

## Verification
The bench builds the engine with a 10-bit address, a 6-bit count and a 3-bit wakeup-disable counter. This gives a 1024-word memory model, with room for a separate destination region for every job. It sweeps every count from 0 to 12, which covers both parities, the zero job and several whole pairs, and it checks the address order, the per-index key and the cycle count for each job. Further runs cover an interrupt held back by a nonzero disable count and a single-word job with the interrupt pending. A yield at the first pair boundary is followed by a resume, and the bench also runs an in-place job and fires a stray start in the middle of a job.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_WRITE, S_PAIR
  } xmState_t;

  typedef struct packed {
    logic ld;      // capture operands
    logic dec;     // step the count down
    logic rd;      // read source word
    logic wr;      // write keyed word
    logic keySel;  // 0: keyA, 1: keyB
    logic fin;     // normal completion
    logic yld;     // stop for interrupt
  } xmStrobes_t;
endpackage

// File: rtl/xm_ctrl.sv
module xm_ctrl
  import xm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       resume,
  input  logic       cntZero,
  input  logic       irqPending,
  input  logic       wakeZero,
  output xmStrobes_t strb,
  output logic       busy,
  output logic       done,
  output logic       yielded
);
  xmState_t state;
  logic     oddWord;
  logic     takeIrq;

  assign takeIrq = irqPending && wakeZero;
  assign busy    = (state != S_IDLE);

  always_comb begin
    strb = '0;
    strb.keySel = oddWord;
    case (state)
      S_IDLE:  strb.ld  = start;
      S_CHECK: begin
        strb.dec = !cntZero;
        strb.fin = cntZero;
      end
      S_READ:  strb.rd  = 1'b1;
      S_WRITE: strb.wr  = 1'b1;
      S_PAIR:  strb.yld = takeIrq;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      oddWord <= 1'b0;
      done    <= 1'b0;
      yielded <= 1'b0;
    end else begin
      done    <= 1'b0;
      yielded <= 1'b0;
      case (state)
        S_IDLE: if (start || resume) begin
          state   <= S_CHECK;
          oddWord <= 1'b0;
        end
        S_CHECK: if (cntZero) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end else begin
          state <= S_READ;
        end
        S_READ:  state <= S_WRITE;
        S_WRITE: if (!oddWord) begin
          oddWord <= 1'b1;
          state   <= S_CHECK;
        end else begin
          oddWord <= 1'b0;
          state   <= S_PAIR;
        end
        S_PAIR: if (takeIrq) begin
          state   <= S_IDLE;
          yielded <= 1'b1;
        end else begin
          state <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: a write always follows the read of the same word
  p_write_after_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |-> $past(strb.rd));
  // R7: the two end pulses never coincide
  p_end_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && yielded));
  // R9: busy drops only with an end pulse
  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || yielded));
  // R5: a yield comes only from a pair boundary
  p_yield_at_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    yielded |-> $past(state == S_PAIR));
endmodule

// File: rtl/xm_dpath.sv
module xm_dpath
  import xm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int SDW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  xmStrobes_t     strb,
  input  logic [AW-1:0]  srcAddr,
  input  logic [AW-1:0]  dstAddr,
  input  logic [CW-1:0]  wordCount,
  input  logic [DW-1:0]  keyA,
  input  logic [DW-1:0]  keyB,
  input  logic [DW-1:0]  memRdata,
  output logic           memReq,
  output logic           memWe,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  output logic           cntZero,
  output logic [CW-1:0]  remCount,
  output logic [SDW-1:0] stackDepth
);
  localparam logic [SDW-1:0] RestartDepth = SDW'(1);

  logic [AW-1:0] srcQ, dstQ, offset;
  logic [CW-1:0] cntQ;
  logic [DW-1:0] keyAQ, keyBQ;

  assign cntZero  = (cntQ == '0);
  assign remCount = cntQ;
  assign offset   = AW'(cntQ);
  assign memReq   = strb.rd || strb.wr;
  assign memWe    = strb.wr;
  assign memAddr  = (strb.wr ? dstQ : srcQ) + offset;
  assign memWdata = memRdata ^ (strb.keySel ? keyBQ : keyAQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ       <= '0;
      dstQ       <= '0;
      cntQ       <= '0;
      keyAQ      <= '0;
      keyBQ      <= '0;
      stackDepth <= '0;
    end else begin
      if (strb.ld) begin
        srcQ  <= srcAddr;
        dstQ  <= dstAddr;
        cntQ  <= wordCount;
        keyAQ <= keyA;
        keyBQ <= keyB;
      end else if (strb.dec) begin
        cntQ <= cntQ - 1'b1;
      end
      if (strb.fin)      stackDepth <= '0;
      else if (strb.yld) stackDepth <= RestartDepth;
    end
  end

  // R2: each step lowers the count by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> (cntQ == $past(cntQ) - 1'b1));
  // R4: never step below zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> !cntZero);
  // R10: one access per cycle
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rd, strb.wr}));
  // R8: completion leaves an empty restart indication
  p_stack_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.fin |=> (stackDepth == '0));
endmodule

// File: rtl/xor_mover.sv
module xor_mover
  import xm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int WDW = 8,
  parameter int SDW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           resume,
  input  logic [AW-1:0]  srcAddr,
  input  logic [AW-1:0]  dstAddr,
  input  logic [CW-1:0]  wordCount,
  input  logic [DW-1:0]  keyA,
  input  logic [DW-1:0]  keyB,
  input  logic           irqPending,
  input  logic [WDW-1:0] wakeDisable,
  input  logic [DW-1:0]  memRdata,
  output logic           memReq,
  output logic           memWe,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  output logic           busy,
  output logic           done,
  output logic           yielded,
  output logic [CW-1:0]  remCount,
  output logic [SDW-1:0] stackDepth
);
  xmStrobes_t strb;
  logic       cntZero;
  logic       wakeZero;

  assign wakeZero = (wakeDisable == '0);

  xm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume),
    .cntZero(cntZero), .irqPending(irqPending), .wakeZero(wakeZero),
    .strb(strb), .busy(busy), .done(done), .yielded(yielded)
  );

  xm_dpath #(.AW(AW), .DW(DW), .CW(CW), .SDW(SDW)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wordCount(wordCount),
    .keyA(keyA), .keyB(keyB), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .cntZero(cntZero), .remCount(remCount), .stackDepth(stackDepth)
  );
endmodule

// File: tb/test_xor_mover.sv
module test_xor_mover;
  localparam int ClkPeriod = 10;
  localparam int AW = 10, DW = 16, CW = 6, WDW = 3, SDW = 3;
  localparam int MemWords = 1 << AW;

  logic clk = 0, rstN = 0, start = 0, resume = 0, irqPending = 0;
  logic [AW-1:0] srcAddr = '0, dstAddr = '0;
  logic [CW-1:0] wordCount = '0;
  logic [DW-1:0] keyA = 16'h3C96, keyB = 16'hA50F;
  logic [WDW-1:0] wakeDisable = '0;
  logic [DW-1:0] memRdata;
  logic memReq, memWe, busy, done, yielded;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [CW-1:0] remCount;
  logic [SDW-1:0] stackDepth;

  int checks = 0, fails = 0, cycles = 0;
  logic [DW-1:0] mem [0:MemWords-1];
  logic [AW-1:0] wrLog [0:63];
  logic [AW-1:0] rdLog [0:63];
  int wrN = 0, rdN = 0;
  logic logClr = 0;

  xor_mover #(.AW(AW), .DW(DW), .CW(CW), .WDW(WDW), .SDW(SDW)) i_xor_mover (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wordCount(wordCount),
    .keyA(keyA), .keyB(keyB), .irqPending(irqPending), .wakeDisable(wakeDisable),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .busy(busy), .done(done), .yielded(yielded),
    .remCount(remCount), .stackDepth(stackDepth)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [DW-1:0] initVal(int a);
    return DW'(a * 16'h03B1) ^ 16'h5AC3;
  endfunction

  initial for (int i = 0; i < MemWords; i++) mem[i] = initVal(i);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memReq && memWe) mem[memAddr] <= memWdata;
    if (memReq && !memWe) memRdata <= mem[memAddr];
    if (logClr) begin
      wrN <= 0; rdN <= 0;
    end else if (memReq) begin
      if (memWe) begin wrLog[wrN % 64] <= memAddr; wrN <= wrN + 1; end
      else       begin rdLog[rdN % 64] <= memAddr; rdN <= rdN + 1; end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic isResume, input int src, input int dst, input int n,
                        input logic irq, input int wd);
    @(negedge clk);
    logClr = 1;
    @(negedge clk);
    logClr = 0;
    srcAddr = AW'(src); dstAddr = AW'(dst); wordCount = CW'(n);
    irqPending = irq; wakeDisable = WDW'(wd);
    if (isResume) resume = 1; else start = 1;
    @(negedge clk);
    start = 0; resume = 0;
  endtask

  // returns busy cycles; optionally pokes a stray start mid-job
  task automatic waitEnd(input logic poke, output int busyCyc);
    busyCyc = 0;
    while (busy && cycles < 150000) begin
      busyCyc++;
      if (poke && busyCyc == 4) begin
        start = 1; srcAddr = AW'(0); wordCount = CW'(3); keyA = 16'hFFFF;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
  endtask

  function automatic logic [DW-1:0] expWord(int src, int j, int n, logic [DW-1:0] ka,
                                            logic [DW-1:0] kb);
    return initVal(src + j) ^ (((n - 1 - j) % 2 == 0) ? ka : kb);
  endfunction

  task automatic verifyBlock(input int src, input int dst, input int n,
                             input logic [DW-1:0] ka, input logic [DW-1:0] kb);
    for (int j = 0; j < n; j++)
      check(mem[(dst + j) % MemWords] == expWord(src, j, n, ka, kb),
            (((n - 1 - j) % 2) == 0) ? "R3 keyA word" : "R3 keyB word",
            mem[(dst + j) % MemWords], expWord(src, j, n, ka, kb));
    check(mem[(dst + n) % MemWords] == initVal(dst + n), "R2 above block untouched",
          mem[(dst + n) % MemWords], initVal(dst + n));
    check(mem[(dst + MemWords - 1) % MemWords] == initVal(dst - 1), "R2 below block untouched",
          mem[(dst + MemWords - 1) % MemWords], initVal(dst - 1));
  endtask

  task automatic checkOrder(input int src, input int dst, input int n, input int first);
    for (int k = 0; k < n; k++) begin
      check(wrLog[k] == AW'(dst + first - 1 - k), "R2 write order", wrLog[k], dst + first - 1 - k);
      check(rdLog[k] == AW'(src + first - 1 - k), "R2 read order", rdLog[k], src + first - 1 - k);
    end
  endtask

  initial begin
    int bc;
    int src, dst;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busy == 0, "R9 reset busy", busy, 0);
    check(done == 0 && yielded == 0, "R9 reset pulses", {done, yielded}, 0);
    check(stackDepth == 0, "R8 reset depth", stackDepth, 0);
    check(memReq == 0, "R10 reset idle port", memReq, 0);

    // sweep counts 0..12, no interrupts
    src = 16;
    for (int n = 0; n <= 12; n++) begin
      dst = 256 + n * 20;
      launch(0, src, dst, n, 0, 0);
      waitEnd(0, bc);
      check(done == 1, "R1 done pulse", done, 1);
      check(stackDepth == 0, "R8 depth cleared", stackDepth, 0);
      check(bc == 3 * n + n / 2 + 1, "R11 busy cycles", bc, 3 * n + n / 2 + 1);
      check(wrN == n, (n == 0) ? "R1 no writes" : "R4 write count", wrN, n);
      checkOrder(src, dst, n, n);
      verifyBlock(src, dst, n, keyA, keyB);
    end

    // interrupt held off by nonzero disable count
    launch(0, src, 576, 9, 1, 3);
    waitEnd(0, bc);
    check(done == 1 && yielded == 0, "R6 completes", {done, yielded}, 2);
    check(bc == 32, "R6 busy cycles", bc, 32);
    verifyBlock(src, 576, 9, keyA, keyB);

    // single word with interrupt pending: no pair, no sample
    launch(0, src, 608, 1, 1, 0);
    waitEnd(0, bc);
    check(done == 1 && yielded == 0, "R4 single word completes", {done, yielded}, 2);
    verifyBlock(src, 608, 1, keyA, keyB);

    // yield after first pair, then resume
    launch(0, src, 640, 10, 1, 0);
    waitEnd(0, bc);
    check(yielded == 1 && done == 0, "R5 yield pulse", {done, yielded}, 1);
    check(bc == 7, "R5 yield after pair", bc, 7);
    check(remCount == 8, "R7 remaining count", remCount, 8);
    check(stackDepth == 1, "R7 restart depth", stackDepth, 1);
    check(wrN == 2, "R5 two words written", wrN, 2);
    check(mem[640 + 7] == initVal(640 + 7), "R7 rest untouched", mem[647], initVal(647));
    launch(1, 0, 0, 0, 0, 0);
    waitEnd(0, bc);
    check(done == 1, "R7 resume completes", done, 1);
    check(stackDepth == 0, "R8 depth after resume", stackDepth, 0);
    check(wrN == 8, "R7 remaining writes", wrN, 8);
    check(wrLog[0] == AW'(640 + 7), "R7 resume starts below", wrLog[0], 647);
    verifyBlock(src, 640, 10, keyA, keyB);

    // in place
    launch(0, 768, 768, 7, 0, 0);
    waitEnd(0, bc);
    check(done == 1, "R10 in-place done", done, 1);
    for (int j = 0; j < 7; j++)
      check(mem[768 + j] == expWord(768, j, 7, keyA, keyB), "R10 in-place word",
            mem[768 + j], expWord(768, j, 7, keyA, keyB));

    // stray start while busy
    launch(0, src, 800, 6, 0, 0);
    waitEnd(1, bc);
    keyA = 16'h3C96;
    check(bc == 22, "R9 start ignored timing", bc, 22);
    check(wrN == 6, "R9 start ignored count", wrN, 6);
    verifyBlock(src, 800, 6, 16'h3C96, keyB);

    if (cycles >= 150000) check(0, "watchdog", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(ClkPeriod * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule